// File: doc/BRIEF.md
# Boundary-Scan Data Register with Shadow Stage

This block is the boundary-scan data register of a scan-testable bus transceiver. It has 44 cells. Each cell pairs a shift flop with a shadow (update) flop. The shift flops form one serial chain. Cell 43 takes test data in, and cell 0 drives test data out. Strobes arrive from an external TAP controller, and a capture-source select arrives from an external instruction decoder; the block sees all of these as plain inputs.

In a capture cycle the whole chain loads in parallel, either from the internal logic outputs or from the external pin inputs. In a shift cycle the chain moves one place toward the serial output. An update cycle copies the chain into the shadow stage. The shadow vector drives test values onto the outputs. Its top four cells carry the decoded output-enable controls for the two ports. Each bidirectional pin owns a single cell that holds both its input and its output value.

A reset, either power-up or a test-logic-reset strobe, clears only those four control cells, so every driven port floats in test mode. The other cells keep whatever value they held. While the TAP sits in run-test/idle, an instruction can ask the chain to re-sample its selected source on every clock.

Top module: `bsr_chain`

## Requirements
- R1: After an active-low power-up reset, bits 43..40 of the shift chain and of the shadow vector are 0. An update right after reset therefore leaves shadow bits 43..40 at 0.
- R2: A capture strobe with source select 0 loads every shift cell i from core vector bit i. Cell 0 then appears on the serial output in the next cycle.
- R3: A capture strobe with source select 1 loads every shift cell i from pin vector bit i.
- R4: Each shift strobe moves cell i+1 into cell i and loads the serial input into cell 43. The serial output always equals cell 0. After 44 shifts, the bit sent in shift k sits in cell k.
- R5: An update strobe copies all 44 shift cells into the shadow vector on that clock. Without an update strobe the shadow vector holds, including during capture and shift.
- R6: An idle-sample strobe reloads the chain from the selected source, exactly as a capture does. While no strobe is active the chain holds.
- R7: A test-logic-reset strobe clears cells 43..40 in both stages and overrides a capture, shift, update or idle-sample strobe given in the same cycle. Cells 39..0 hold their values.
- R8: If capture and shift strobes arrive in the same cycle, the capture wins. If shift and idle-sample strobes arrive together, the shift wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| trst_n_i | input | 1 | Asynchronous power-up reset, active low |
| tlr_i | input | 1 | Test-logic-reset strobe (synchronous) |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| idle_smp_i | input | 1 | Run-test/idle re-sample request from the instruction |
| src_sel_i | input | 1 | Capture source: 0 core logic, 1 pins |
| core_vec_i | input | 44 | Values from the internal logic outputs |
| pin_vec_i | input | 44 | Values seen at the external pins |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out (cell 0) |
| shadow_o | output | 44 | Shadow vector; bits 43..40 are the output-enable controls |

## Verification
The assertions assume the strobes come from a well-behaved TAP controller. Update never arrives with capture or shift, except that a reset strobe may override any of them. The capture source stays stable during the capture cycle. To keep within this, the bench drives each strobe for a single clock in a legal sequence: capture, a run of shifts, then update. The only deliberate overlaps are the reset and priority cases named in R7 and R8. The cells outside 43..40 start undefined, so no check reads them before a capture or a full shift has set them.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef enum logic [2:0] {
      OP_HOLD  = 3'd0,
      OP_CLEAR = 3'd1,
      OP_LOAD  = 3'd2,
      OP_SHIFT = 3'd3,
      OP_IDLE  = 3'd4
   } chain_op_e;

   typedef enum logic {
      SRC_CORE = 1'b0,
      SRC_PIN  = 1'b1
   } cap_src_e;
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
   import bsr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tlr,
   input  logic      capture,
   input  logic      shift,
   input  logic      update,
   input  logic      idle_smp,
   output chain_op_e op,
   output logic      load_en,
   output logic      shift_en,
   output logic      clear_en,
   output logic      upd_en
);
   always_comb begin
      if (tlr)            op = OP_CLEAR;
      else if (capture)   op = OP_LOAD;
      else if (shift)     op = OP_SHIFT;
      else if (idle_smp)  op = OP_IDLE;
      else                op = OP_HOLD;
   end

   assign clear_en = (op == OP_CLEAR);
   assign load_en  = (op == OP_LOAD) || (op == OP_IDLE);
   assign shift_en = (op == OP_SHIFT);
   assign upd_en   = update && !tlr;

   // R7 / R8: one action at most per cycle on the chain
   p_single_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({clear_en, load_en, shift_en}) <= 1);
   p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tlr |-> (clear_en && !upd_en));
endmodule

// File: rtl/bsr_cap_mux.sv
module bsr_cap_mux
   import bsr_pkg::*;
#(
   parameter int unsigned WIDTH = 44
) (
   input  cap_src_e          sel,
   input  logic [WIDTH-1:0]  core_vec,
   input  logic [WIDTH-1:0]  pin_vec,
   output logic [WIDTH-1:0]  cap_vec
);
   if (WIDTH < 1) begin : g_bad_width
      $error("bsr_cap_mux: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign cap_vec[i] = (sel == SRC_PIN) ? pin_vec[i] : core_vec[i];
   end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell #(
   parameter bit   HAS_RESET = 1'b0,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_en,
   input  logic load_en,
   input  logic par_d,
   input  logic shift_en,
   input  logic ser_d,
   input  logic upd_en,
   output logic shf_q,
   output logic shd_q
);
   logic shf_nxt;

   always_comb begin
      shf_nxt = shf_q;
      if (load_en)       shf_nxt = par_d;
      else if (shift_en) shf_nxt = ser_d;
   end

   if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shf_q <= RESET_VAL;
            shd_q <= RESET_VAL;
         end else if (clear_en) begin
            shf_q <= RESET_VAL;
            shd_q <= RESET_VAL;
         end else begin
            shf_q <= shf_nxt;
            if (upd_en) shd_q <= shf_q;
         end
      end
   end else begin : g_plain
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (!clear_en) begin
            shf_q <= shf_nxt;
            if (upd_en) shd_q <= shf_q;
         end
      end
   end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
   import bsr_pkg::*;
#(
   parameter int unsigned N_CELLS  = 44,
   parameter int unsigned N_CTRL   = 4,
   parameter logic        CTRL_RST = 1'b0
) (
   input  logic               tck_i,
   input  logic               trst_n_i,
   input  logic               tlr_i,
   input  logic               capture_i,
   input  logic               shift_i,
   input  logic               update_i,
   input  logic               idle_smp_i,
   input  logic               src_sel_i,
   input  logic [N_CELLS-1:0] core_vec_i,
   input  logic [N_CELLS-1:0] pin_vec_i,
   input  logic               tdi_i,
   output logic               tdo_o,
   output logic [N_CELLS-1:0] shadow_o
);
   localparam int unsigned CTRL_LO = N_CELLS - N_CTRL;

   if (N_CELLS < 2) begin : g_bad_cells
      $error("bsr_chain: N_CELLS must be at least 2");
   end
   if (N_CTRL < 1 || N_CTRL >= N_CELLS) begin : g_bad_ctrl
      $error("bsr_chain: N_CTRL must be in 1..N_CELLS-1");
   end

   chain_op_e          op;
   logic               load_en, shift_en, clear_en, upd_en;
   logic [N_CELLS-1:0] cap_vec;
   logic [N_CELLS-1:0] shf_q;
   logic [N_CELLS-1:0] ser_in;
   cap_src_e           sel;

   assign sel = cap_src_e'(src_sel_i);

   bsr_ctrl u_ctrl (
      .clk      (tck_i),
      .rst_n    (trst_n_i),
      .tlr      (tlr_i),
      .capture  (capture_i),
      .shift    (shift_i),
      .update   (update_i),
      .idle_smp (idle_smp_i),
      .op       (op),
      .load_en  (load_en),
      .shift_en (shift_en),
      .clear_en (clear_en),
      .upd_en   (upd_en)
   );

   bsr_cap_mux #(.WIDTH(N_CELLS)) u_mux (
      .sel      (sel),
      .core_vec (core_vec_i),
      .pin_vec  (pin_vec_i),
      .cap_vec  (cap_vec)
   );

   assign ser_in = {tdi_i, shf_q[N_CELLS-1:1]};

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      bsr_cell #(
         .HAS_RESET (i >= CTRL_LO),
         .RESET_VAL (CTRL_RST)
      ) u_cell (
         .clk      (tck_i),
         .rst_n    (trst_n_i),
         .clear_en (clear_en),
         .load_en  (load_en),
         .par_d    (cap_vec[i]),
         .shift_en (shift_en),
         .ser_d    (ser_in[i]),
         .upd_en   (upd_en),
         .shf_q    (shf_q[i]),
         .shd_q    (shadow_o[i])
      );
   end

   assign tdo_o = shf_q[0];

   // R1 / R7: control cells clear on reset strobe
   p_ctrl_clear_r7: assert property (@(posedge tck_i) disable iff (!trst_n_i)
      tlr_i |=> (shadow_o[N_CELLS-1:CTRL_LO] == {N_CTRL{CTRL_RST}}) &&
                (shf_q[N_CELLS-1:CTRL_LO] == {N_CTRL{CTRL_RST}}));
   // R2
   p_cap_core_r2: assert property (@(posedge tck_i) disable iff (!trst_n_i)
      (capture_i && !tlr_i && !src_sel_i) |=> (shf_q == $past(core_vec_i)));
   // R3
   p_cap_pin_r3: assert property (@(posedge tck_i) disable iff (!trst_n_i)
      (capture_i && !tlr_i && src_sel_i) |=> (shf_q == $past(pin_vec_i)));
   // R4
   p_shift_r4: assert property (@(posedge tck_i) disable iff (!trst_n_i)
      (shift_i && !capture_i && !tlr_i) |=>
         (shf_q[N_CELLS-2:0] == $past(shf_q[N_CELLS-1:1])) &&
         (shf_q[N_CELLS-1] == $past(tdi_i)));
   // R5
   p_update_r5: assert property (@(posedge tck_i) disable iff (!trst_n_i)
      (update_i && !tlr_i) |=> (shadow_o == $past(shf_q)));
   p_shadow_hold_r5: assert property (@(posedge tck_i) disable iff (!trst_n_i)
      (!update_i && !tlr_i) |=> $stable(shadow_o));
   // R6
   p_idle_sample_r6: assert property (@(posedge tck_i) disable iff (!trst_n_i)
      (idle_smp_i && !shift_i && !capture_i && !tlr_i) |=>
         (shf_q == $past(src_sel_i ? pin_vec_i : core_vec_i)));
endmodule

// File: tb/sim_bsr_chain.sv
module sim_bsr_chain;
   localparam int N = 44;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tlr = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, idl = 1'b0;
   logic          sel = 1'b0, tdi = 1'b0;
   logic [N-1:0]  core_v = '0, pin_v = '0;
   logic          tdo;
   logic [N-1:0]  shadow;

   int            checks = 0;
   int            failures = 0;
   bit            mon_en = 1'b0;
   string         mon_tag = "R4";
   logic          exp_q[$];

   always #5 clk = ~clk;

   bsr_chain u0 (
      .tck_i(clk), .trst_n_i(rst_n), .tlr_i(tlr), .capture_i(cap),
      .shift_i(shf), .update_i(upd), .idle_smp_i(idl), .src_sel_i(sel),
      .core_vec_i(core_v), .pin_vec_i(pin_v), .tdi_i(tdi),
      .tdo_o(tdo), .shadow_o(shadow)
   );

   // monitor: compare serial output against scoreboard queue
   always @(negedge clk) begin
      if (mon_en) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL %s: tdo=%b with empty scoreboard", mon_tag, tdo);
         end else begin
            logic e;
            e = exp_q.pop_front();
            if (tdo !== e) begin
               failures++;
               $display("FAIL %s: tdo actual=%b expected=%b", mon_tag, tdo, e);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // shift N bits out; expect 'exp' from cell 0 upward, send 'w' in
   task automatic scan_out(string tag, logic [N-1:0] exp, logic [N-1:0] w);
      for (int k = 0; k < N; k++) exp_q.push_back(exp[k]);
      mon_tag = tag;
      shf = 1'b1;
      mon_en = 1'b1;
      for (int k = 0; k < N; k++) begin
         tdi = w[k];
         step();
      end
      shf = 1'b0;
      mon_en = 1'b0;
   endtask

   task automatic capture(logic s);
      sel = s; cap = 1'b1;
      step();
      cap = 1'b0;
   endtask

   task automatic update();
      upd = 1'b1;
      step();
      upd = 1'b0;
   endtask

   localparam logic [N-1:0] PA = 44'hA5C_3F01_9E7B;
   localparam logic [N-1:0] PB = 44'h3D1_E84C_2A56;
   localparam logic [N-1:0] PC = 44'hF0F_0C3C_5A5A;
   localparam logic [N-1:0] W1 = 44'h96E_1B3D_7C08;
   localparam logic [N-1:0] W2 = 44'h5A1_F2C4_8E3B;
   localparam logic [N-1:0] W3 = 44'hC3B_7A91_0DE6;

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : driver
      logic [N-1:0] keep;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1: shadow control bits after reset
      check_vec("R1 shadow ctrl", {40'd0, shadow[N-1:40]}, '0);
      // R1: shift-stage control bits cleared too, seen through update
      update();
      check_vec("R1 shift ctrl", {40'd0, shadow[N-1:40]}, '0);

      // R2 + R4 + R5: capture core, shift W1 in, update
      core_v = PA; pin_v = PB;
      capture(1'b0);
      scan_out("R2", PA, W1);
      check_vec("R5 hold during shift", {40'd0, shadow[N-1:40]}, '0);
      update();
      check_vec("R4/R5 shadow after update", shadow, W1);

      // R3: capture pins
      capture(1'b1);
      scan_out("R3", PB, W2);
      check_vec("R5 no update keeps shadow", shadow, W1);
      update();
      check_vec("R5 shadow W2", shadow, W2);

      // R6: idle sample from pins, then hold with no strobe
      pin_v = PC;
      idl = 1'b1; sel = 1'b1;
      step();
      idl = 1'b0;
      pin_v = PA; core_v = PB;   // changed sources must not reach chain
      repeat (3) step();
      scan_out("R6", PC, W3);

      // R8: capture and shift together, capture wins
      core_v = PB;
      sel = 1'b0; cap = 1'b1; shf = 1'b1;
      step();
      cap = 1'b0; shf = 1'b0;
      scan_out("R8 cap over shift", PB, W1);

      // R8: shift and idle-sample together, shift wins
      idl = 1'b1;
      scan_out("R8 shift over idle", W1, W2);
      idl = 1'b0;

      // R7: reset strobe overrides shift and update; low cells hold
      update();
      keep = shadow;
      check_vec("R5 shadow W2 again", shadow, W2);
      tlr = 1'b1; shf = 1'b1; upd = 1'b1; cap = 1'b1;
      step();
      tlr = 1'b0; shf = 1'b0; upd = 1'b0; cap = 1'b0;
      check_vec("R7 ctrl cleared", shadow, {4'd0, keep[39:0]});
      scan_out("R7 chain after clear", {4'd0, W2[39:0]}, W3);
      update();
      check_vec("R4 shadow W3", shadow, W3);

      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R4: %0d expected bits never observed", exp_q.size());
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule